// File: doc/BRIEF.md
# USB Line Receiver with Preamble Detect

This block sits behind the D+/D- pins of a USB port, sampled once per clock of a 48 MHz sample clock. It sorts every sample into one of four line states. It spots the J-to-K edge that opens a packet and recovers bit timing with a fractional bit-period counter. It then undoes NRZI coding, drops stuffed bits and hands each data bit to the packet layer with a one-cycle strobe. It marks packet start and end with single-cycle pulses. The sync field is included in the delivered bits.

The receiver also watches the first sixteen bits of every packet. When they form sync followed by the preamble PID, a full-speed host is announcing low-speed traffic. The receiver closes that short packet at once and switches itself to low-speed bit timing. It decodes the next packet at that rate and falls back to full-speed timing at that packet's end. Line polarity stays on the full-speed mapping throughout. PID decoding, CRC checking and packet assembly are left to the next layer.

Top module: `usb_line_rx`

## Requirements
- R1: Line states are {dp,dm}: 2'b10 is J, 2'b01 is K, 2'b00 is SE0 and 2'b11 is SE1. While idle, a start-of-packet pulse is given only when a K sample directly follows a J sample. No other pair of samples starts a packet.
- R2: Each decoded bit is 0 when the sampled line state differs from the state at the previous bit sample, and 1 when it is the same. The sync field therefore arrives as the bits 0,0,0,0,0,0,0,1.
- R3: The first bit sample falls half a bit period after the J-to-K edge. Later samples follow once per bit period, which is FS_SPB clocks at full speed (4 by default). Each bit that is not stuffed gives one bit_vld pulse with the bit on bit_dat.
- R4: After STUFF_RUN (6) consecutive 1 bits, counted from packet start, the next bit is taken as a stuffed 0 and produces no bit_vld pulse.
- R5: If the bit in the stuffed position is a 1, stuff_err pulses, no bit_vld or eop is given for that bit, and the receiver returns to idle.
- R6: A bit sample that shows SE0 ends bit decoding. eop pulses on the first sample after that which is not SE0.
- R7: If the first sixteen decoded bits, taken in arrival order, equal 0000000100111100, then pre_seen and eop pulse together in the cycle after the sixteenth bit's sample, and the receiver returns to idle.
- R8: After a preamble match, low_speed is 1 and the bit period becomes LS_SPB clocks (32 by default). The NRZI reference state is forced to J, so the next J-to-K edge starts a low-speed packet that decodes correctly.
- R9: low_speed returns to 0 at the eop of the packet that follows the preamble. Later packets use full-speed timing again. low_speed is 0 after reset.
- R10: Timing correction only ever lengthens: within a packet the bit period never shrinks. A correction is made only on a 0 bit whose last line edge reached a J or K state that differs from the sampled state. A one-sample SE1 spike away from the sample point does not change the decoded bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one line sample per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dp | input | 1 | D+ line level, already synchronous to clk |
| dm | input | 1 | D- line level, already synchronous to clk |
| bit_vld | output | 1 | One-cycle strobe: a decoded, unstuffed bit is on bit_dat |
| bit_dat | output | 1 | Decoded bit value |
| sop | output | 1 | One-cycle start-of-packet pulse |
| eop | output | 1 | One-cycle end-of-packet pulse |
| pre_seen | output | 1 | One-cycle pulse when sync plus preamble PID is matched |
| low_speed | output | 1 | 1 while low-speed bit timing is selected |
| stuff_err | output | 1 | One-cycle pulse on a bit-stuffing violation |

## Verification
Plain full-speed packets check NRZI decoding and half-bit sample placement on varied data. A packet with eight 1s in a row checks that the stuffed 0 is removed rather than delivered. An unstuffed run of ones separates the error abort from normal stuffing. A single-sample SE1 spike inside a packet shows that the sample point, not a passing edge, decides the bit. A preamble, then a low-speed packet, then another full-speed packet checks the speed switch, the low-speed bit period, and the return to full speed. A J-free sequence (SE1 then K) confirms that only a J-to-K pair opens a packet.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;
   // line state coded as {dp,dm}
   typedef enum logic [1:0] {
      SYM_SE0 = 2'b00,
      SYM_K   = 2'b01,
      SYM_J   = 2'b10,
      SYM_SE1 = 2'b11
   } line_sym_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DATA = 2'd1,
      ST_EOP  = 2'd2
   } rx_state_e;
endpackage

// File: rtl/usb_sym_class.sv
module usb_sym_class
   import usb_rx_pkg::*;
#(
   parameter bit SWAP_LINES = 1'b0
) (
   input  logic      dp,
   input  logic      dm,
   output line_sym_e sym
);
   generate
      if (SWAP_LINES) begin : g_swap
         assign sym = line_sym_e'({dm, dp});
      end else begin : g_direct
         assign sym = line_sym_e'({dp, dm});
      end
   endgenerate
endmodule

// File: rtl/usb_bit_timer.sv
module usb_bit_timer #(
   parameter int FS_SPB = 4,
   parameter int LS_SPB = 32,
   parameter int FRAC   = 10,
   parameter int PER_SH = 10,
   parameter int PH_SH  = 7,
   parameter int PER_W  = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic             nudge,
   input  logic             ld_ls,
   input  logic             ld_fs,
   output logic             smp,
   output logic [PER_W-1:0] per
);
   localparam logic [PER_W-1:0] ONE_V  = PER_W'(1) << FRAC;
   localparam logic [PER_W-1:0] FS_PER = PER_W'(FS_SPB) << FRAC;
   localparam logic [PER_W-1:0] LS_PER = PER_W'(LS_SPB) << FRAC;

   logic [PER_W-1:0] ph_q, per_q, ph_bump;

   assign smp     = run && (ph_q < ONE_V);
   assign ph_bump = (smp && nudge) ? (per_q >> PH_SH) : '0;
   assign per     = per_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q  <= '0;
         per_q <= FS_PER;
      end else begin
         if (start)
            ph_q <= (per_q >> 1) - ONE_V;
         else if (smp)
            ph_q <= ph_q + per_q + ph_bump - ONE_V;
         else if (run)
            ph_q <= ph_q - ONE_V;

         if (ld_ls)
            per_q <= LS_PER;
         else if (ld_fs)
            per_q <= FS_PER;
         else if (smp && nudge)
            per_q <= per_q + (per_q >> PER_SH);
      end
   end
endmodule

// File: rtl/usb_pre_match.sv
module usb_pre_match #(
   parameter int             LEN = 16,
   parameter logic [LEN-1:0] PAT = 16'b0000_0001_0011_1100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic shift,
   input  logic b,
   output logic hit
);
   localparam int CW = $clog2(LEN + 1);

   logic [LEN-1:0] hist_q;
   logic [CW-1:0]  cnt_q;
   logic [LEN-1:0] hist_n;

   assign hist_n = {hist_q[LEN-2:0], b};
   assign hit    = shift && (cnt_q == CW'(LEN - 1)) && (hist_n == PAT);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         hist_q <= '0;
         cnt_q  <= '0;
      end else if (shift && (cnt_q < CW'(LEN))) begin
         hist_q <= hist_n;
         cnt_q  <= cnt_q + CW'(1);
      end
   end
endmodule

// File: rtl/usb_line_rx.sv
module usb_line_rx
   import usb_rx_pkg::*;
#(
   parameter int          FS_SPB    = 4,
   parameter int          LS_SPB    = 32,
   parameter int          FRAC      = 10,
   parameter int          STUFF_RUN = 6,
   parameter logic [15:0] PRE_PAT   = 16'b0000_0001_0011_1100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dp,
   input  logic dm,
   output logic bit_vld,
   output logic bit_dat,
   output logic sop,
   output logic eop,
   output logic pre_seen,
   output logic low_speed,
   output logic stuff_err
);
   localparam int PER_W = $clog2(LS_SPB) + FRAC + 2;
   localparam int OW    = $clog2(STUFF_RUN + 1);

   generate
      if (FS_SPB < 4) begin : g_bad_fs
         $error("FS_SPB must be at least 4");
      end
      if (LS_SPB <= FS_SPB) begin : g_bad_ls
         $error("LS_SPB must exceed FS_SPB");
      end
      if (FRAC < 10) begin : g_bad_frac
         $error("FRAC too small for drift steps");
      end
   endgenerate

   line_sym_e        sym, line_q, edge_q, ref_q;
   rx_state_e        st_q;
   logic [OW-1:0]    ones_q;
   logic             ls_q;
   logic             smp, hit, b, dec, stuff_slot;
   logic             sop_c, err_c, emit_c, nudge_c, eop_c, ld_fs;
   logic [PER_W-1:0] per_w;
   logic             in_pkt;

   usb_sym_class u_cls (.dp(dp), .dm(dm), .sym(sym));

   usb_bit_timer #(
      .FS_SPB(FS_SPB), .LS_SPB(LS_SPB), .FRAC(FRAC), .PER_W(PER_W)
   ) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(sop_c), .run(in_pkt),
      .nudge(nudge_c), .ld_ls(hit), .ld_fs(ld_fs), .smp(smp), .per(per_w)
   );

   usb_pre_match #(.LEN(16), .PAT(PRE_PAT)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr(sop_c), .shift(dec), .b(b), .hit(hit)
   );

   always_comb begin
      in_pkt     = (st_q == ST_DATA);
      sop_c      = (st_q == ST_IDLE) && (line_q == SYM_J) && (sym == SYM_K);
      b          = (sym == ref_q);
      dec        = smp && (sym != SYM_SE0);
      stuff_slot = (ones_q == OW'(STUFF_RUN));
      err_c      = dec && !hit && stuff_slot && b;
      emit_c     = dec && !stuff_slot;
      nudge_c    = dec && !b && ((edge_q == SYM_J) || (edge_q == SYM_K))
                   && (edge_q != sym);
      ld_fs      = (st_q == ST_EOP) && (sym != SYM_SE0) && ls_q;
      eop_c      = hit || ((st_q == ST_EOP) && (sym != SYM_SE0));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         line_q    <= SYM_J;
         edge_q    <= SYM_J;
         ref_q     <= SYM_J;
         ones_q    <= '0;
         ls_q      <= 1'b0;
         bit_vld   <= 1'b0;
         bit_dat   <= 1'b0;
         sop       <= 1'b0;
         eop       <= 1'b0;
         pre_seen  <= 1'b0;
         stuff_err <= 1'b0;
      end else begin
         line_q <= sym;
         if (sym != line_q)
            edge_q <= sym;

         case (st_q)
            ST_IDLE: if (sop_c) st_q <= ST_DATA;
            ST_DATA: begin
               if (smp && (sym == SYM_SE0)) st_q <= ST_EOP;
               else if (hit || err_c)       st_q <= ST_IDLE;
            end
            ST_EOP:  if (sym != SYM_SE0) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase

         if (sop_c)
            ref_q <= SYM_J;
         else if (smp)
            ref_q <= hit ? SYM_J : sym;

         if (sop_c)
            ones_q <= '0;
         else if (dec)
            ones_q <= (stuff_slot || !b) ? '0 : ones_q + OW'(1);

         if (hit)
            ls_q <= 1'b1;
         else if (ld_fs)
            ls_q <= 1'b0;

         bit_vld   <= emit_c;
         bit_dat   <= emit_c ? b : 1'b0;
         sop       <= sop_c;
         eop       <= eop_c;
         pre_seen  <= hit;
         stuff_err <= err_c;
      end
   end

   assign low_speed = ls_q;
endmodule

// File: rtl/usb_line_rx_chk.sv
module usb_line_rx_chk #(
   parameter int PER_W = 17
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dp,
   input logic             dm,
   input logic             bit_vld,
   input logic             sop,
   input logic             eop,
   input logic             pre_seen,
   input logic             low_speed,
   input logic             stuff_err,
   input logic             in_pkt,
   input logic [PER_W-1:0] per
);
   // R1: a start pulse follows a J sample then a K sample
   p_sop_after_jk_r1: assert property (@(posedge clk) disable iff (!rst_n)
      sop |-> ($past(dp) == 1'b0 && $past(dm) == 1'b1 &&
               $past(dp, 2) == 1'b1 && $past(dm, 2) == 1'b0));

   // R5: an abort carries neither a bit nor an end marker
   p_err_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stuff_err |-> (!bit_vld && !eop));

   // R7: a preamble match closes the packet in the same cycle
   p_pre_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pre_seen |-> eop);

   // R8: a preamble match selects low speed
   p_pre_sets_ls_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pre_seen |-> low_speed);

   // R9: any other end of packet leaves full speed selected
   p_eop_clears_ls_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (eop && !pre_seen) |-> !low_speed);

   // R10: the bit period never shrinks inside a packet
   p_period_grows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_pkt && $past(in_pkt)) |-> (per >= $past(per)));
endmodule

bind usb_line_rx usb_line_rx_chk #(.PER_W(PER_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .dp(dp), .dm(dm), .bit_vld(bit_vld),
   .sop(sop), .eop(eop), .pre_seen(pre_seen), .low_speed(low_speed),
   .stuff_err(stuff_err), .in_pkt(in_pkt), .per(per_w)
);

// File: tb/test_usb_line_rx.sv
module test_usb_line_rx;
   localparam int FS = 4;
   localparam int LS = 32;
   localparam logic [1:0] L_J = 2'b10, L_K = 2'b01, L_SE0 = 2'b00, L_SE1 = 2'b11;
   localparam int E_SOP = 1, E_BIT = 2, E_PRE = 3, E_EOP = 4, E_ERR = 5;

   typedef struct {
      int    k;
      int    v;
      string tag;
   } item_t;

   logic clk = 1'b0, rst_n = 1'b0, dp = 1'b1, dm = 1'b0;
   logic bit_vld, bit_dat, sop, eop, pre_seen, low_speed, stuff_err;

   item_t      exp_q[$];
   int         nrun = 0, nfail = 0, nev = 0;
   bit         done = 1'b0;
   logic [1:0] cur;
   logic [7:0] pb[4];

   always #10 clk = ~clk;

   usb_line_rx i_usb_line_rx (
      .clk(clk), .rst_n(rst_n), .dp(dp), .dm(dm), .bit_vld(bit_vld),
      .bit_dat(bit_dat), .sop(sop), .eop(eop), .pre_seen(pre_seen),
      .low_speed(low_speed), .stuff_err(stuff_err)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nrun++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic push(input int k, input int v, input string tag);
      item_t it;
      it.k = k; it.v = v; it.tag = tag;
      exp_q.push_back(it);
   endtask

   task automatic take(input int k, input int v);
      item_t it;
      nev++;
      if (exp_q.size() == 0) begin
         chk(1'b0, "R1 unexpected event kind", k, 0);
      end else begin
         it = exp_q.pop_front();
         chk(it.k == k && it.v == v, it.tag, k * 10 + v, it.k * 10 + it.v);
      end
   endtask

   // scoreboard monitor, samples away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (sop)       take(E_SOP, 0);
         if (bit_vld)   take(E_BIT, int'(bit_dat));
         if (pre_seen)  take(E_PRE, 0);
         if (eop)       take(E_EOP, 0);
         if (stuff_err) take(E_ERR, 0);
      end
   end

   task automatic hold(input logic [1:0] s, input int n);
      for (int i = 0; i < n; i++) begin
         {dp, dm} = s;
         @(negedge clk);
      end
   endtask

   task automatic drive_bit(input bit b, input int spb, input bit glitch);
      if (!b) cur = ~cur;
      for (int j = 0; j < spb; j++) begin
         {dp, dm} = (glitch && j == 0) ? L_SE1 : cur;
         @(negedge clk);
      end
   endtask

   task automatic send_pkt(input int nb, input int spb, input bit pre_only,
                           input string tag, input int glitch);
      int  ones = 0;
      int  pos  = 0;
      bit  b;
      bit  after_stuff = 1'b0;
      cur = L_J;
      push(E_SOP, 0, "R1");
      for (int i = 0; i < 8 + nb * 8; i++) begin
         b = (i < 8) ? (i == 7) : pb[(i - 8) / 8][(i - 8) % 8];
         push(E_BIT, int'(b), (i < 8) ? "R2" : (after_stuff ? "R4" : tag));
         after_stuff = 1'b0;
         if (pre_only && i == 15) begin
            push(E_PRE, 0, "R7");
            push(E_EOP, 0, "R7");
         end
         drive_bit(b, spb, pos == glitch);
         pos++;
         ones = b ? ones + 1 : 0;
         if (ones == 6) begin
            drive_bit(1'b0, spb, 1'b0);
            pos++;
            ones = 0;
            after_stuff = 1'b1;
         end
      end
      if (!pre_only) begin
         push(E_EOP, 0, "R6");
         hold(L_SE0, 2 * spb);
         hold(L_J, spb);
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk(!bit_vld && !sop && !eop && !pre_seen && !stuff_err, "R1 reset outputs",
          int'({bit_vld, sop, eop, pre_seen, stuff_err}), 0);
      chk(!low_speed, "R9 reset speed", int'(low_speed), 0);
      rst_n = 1'b1;
      hold(L_J, 10);

      // R1: SE1 then K must not open a packet
      hold(L_SE1, 3);
      hold(L_K, 6);
      hold(L_J, 6);
      chk(nev == 0, "R1 no start without J-to-K", nev, 0);

      // R2/R3: plain full-speed packet
      pb[0] = 8'h69; pb[1] = 8'h35;
      send_pkt(2, FS, 1'b0, "R3", -1);
      hold(L_J, 6);

      // R4: long run of ones forces a stuffed bit
      pb[0] = 8'hFF; pb[1] = 8'h81;
      send_pkt(2, FS, 1'b0, "R3", -1);
      hold(L_J, 6);

      // R10: SE1 spike off the sample point
      pb[0] = 8'hA5; pb[1] = 8'h0F;
      send_pkt(2, FS, 1'b0, "R10", 12);
      hold(L_J, 6);

      // R5: seven ones in a row without stuffing
      cur = L_J;
      push(E_SOP, 0, "R1");
      for (int i = 0; i < 8; i++) begin
         push(E_BIT, int'(i == 7), "R2");
         drive_bit(i == 7, FS, 1'b0);
      end
      for (int i = 0; i < 6; i++) begin
         if (i < 5) push(E_BIT, 1, "R5");
         else       push(E_ERR, 0, "R5");
         drive_bit(1'b1, FS, 1'b0);
      end
      hold(L_SE0, 2 * FS);
      hold(L_J, 10);

      // R7: sync plus preamble PID
      pb[0] = 8'h3C;
      send_pkt(1, FS, 1'b1, "R7", -1);
      hold(L_J, 40);
      chk(low_speed, "R8 speed after preamble", int'(low_speed), 1);

      // R8: low-speed packet at the new period
      pb[0] = 8'h2D; pb[1] = 8'h00;
      send_pkt(2, LS, 1'b0, "R8", -1);
      hold(L_J, 10);
      chk(!low_speed, "R9 speed after low-speed end", int'(low_speed), 0);

      // R9: full speed works again
      pb[0] = 8'hC3;
      send_pkt(1, FS, 1'b0, "R9", -1);
      hold(L_J, 20);

      chk(exp_q.size() == 0, "R6 events left unseen", exp_q.size(), 0);
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", nrun, nfail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         nrun++;
         nfail++;
         $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", nrun, nfail);
         $finish;
      end
   end
endmodule